// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Vector Address Generation

This block sits on the processor side of the interrupt path. It watches four sources of interrupt: an internal fault strobe carrying its own type number, a non-maskable input pin, a software interrupt strobe with its type number, and a level-sensitive maskable request from an external controller. At each instruction boundary, marked by a one-cycle `insn_end` pulse, it picks the most urgent pending source and starts an entry sequence for it. Lower-ranked sources stay pending for later boundaries.

For a maskable request, the block first runs two acknowledge pulses on `ack_o`. It reads the 8-bit type number from `ack_data` during the last cycle of the second pulse. The other three classes carry their type number without any acknowledge cycles. Each entry leaves the block as one item on a valid/ready output stream. The item carries the class, the type, the handler offset-word and segment-word addresses in the vector table, and the enable and trap flags that the stacking logic must save. The block owns the enable and trap flags. Instruction execution writes them through a plain write port. A return-from-interrupt strobe restores them from the values popped off the stack. Accepting an entry clears both flags.

The output stream follows the usual rules. `entry_valid` rises only when an item is complete. It stays high, with every field unchanged, until a cycle in which `entry_ready` is high. The item is consumed at that clock edge. While an item waits, no new entry starts and instruction boundaries are ignored. Sources that arrive meanwhile are latched.

Top module: `int_entry_seq`

## Requirements
- R1: After reset `entry_valid`, `ack_o`, `if_o` and `tf_o` are all 0.
- R2: When several sources are pending at one boundary, only the highest-ranked one is taken, in the order fault, non-maskable, software, maskable. `entry_class` encodes these as 0, 1, 2 and 3.
- R3: The maskable level on `intr_lvl` is looked at only in a cycle with `insn_end` high, and only while `if_o` is 1. At any other time it starts nothing.
- R4: A maskable entry drives `ack_o` high for two pulses of ACK_LEN cycles each (default 2), separated by ACK_GAP low cycles (default 2). `entry_type` is the value of `ack_data[7:0]` in the last cycle of the second pulse. No other class drives `ack_o`.
- R5: Software and fault interrupts are taken whatever the value of `if_o`. A strobe seen in the same cycle as `insn_end` is taken at that boundary. A fault entry reports `flt_type` (type 0 for a divide error, type 4 for the overflow trap) and a software entry reports `swi_type`.
- R6: The non-maskable pin is latched only after it is sampled low and then high on two consecutive clocks. A one-cycle high pulse is ignored. The entry always has type 2.
- R7: `entry_off_addr` is the type times 4, as a 10-bit address. `entry_seg_addr` is that address plus 2.
- R8: `entry_valid` stays high with all fields stable until `entry_ready` is high. `entry_sv_if` and `entry_sv_tf` hold the flag values from the cycle in which the source was taken. When the item is accepted, `if_o` and `tf_o` both become 0.
- R9: `iret_stb` loads `if_o` and `tf_o` from `iret_if` and `iret_tf`. `flag_wr` loads them from `flag_if` and `flag_tf`.
- R10: Sources that are not taken stay pending and are taken at later boundaries. A non-maskable edge that arrives while an entry is in progress is kept. Boundaries seen while an entry is in progress have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_end | input | 1 | Last clock of an instruction |
| intr_lvl | input | 1 | Maskable level request |
| nmi_pin | input | 1 | Non-maskable request pin |
| swi_stb | input | 1 | Software interrupt strobe |
| swi_type | input | 8 | Software interrupt type |
| flt_stb | input | 1 | Internal fault strobe |
| flt_type | input | 8 | Internal fault type |
| ack_o | output | 1 | Acknowledge pulse to the external controller |
| ack_data | input | 8 | Type byte from the external controller |
| flag_wr | input | 1 | Flag write from instruction execution |
| flag_if | input | 1 | Enable flag value to write |
| flag_tf | input | 1 | Trap flag value to write |
| iret_stb | input | 1 | Return-from-interrupt strobe |
| iret_if | input | 1 | Enable flag popped from the stack |
| iret_tf | input | 1 | Trap flag popped from the stack |
| if_o | output | 1 | Current enable flag |
| tf_o | output | 1 | Current trap flag |
| entry_valid | output | 1 | Entry item valid |
| entry_ready | input | 1 | Stacking logic accepts the item |
| entry_class | output | 2 | Class of the entry (0 fault, 1 non-maskable, 2 software, 3 maskable) |
| entry_type | output | 8 | Type number |
| entry_off_addr | output | 10 | Vector-table address of the offset word |
| entry_seg_addr | output | 10 | Vector-table address of the segment word |
| entry_sv_if | output | 1 | Enable flag to save |
| entry_sv_tf | output | 1 | Trap flag to save |

## Verification
A stale pending latch shows up at the next boundary: an entry of the wrong class appears, or an extra entry appears that the scoreboard did not expect. A fault in the non-maskable edge qualifier shows up the same way, with an entry after a one-cycle glitch or a missing type-2 entry. A wrong phase counter in the acknowledge sequencer changes the pulse count or the pulse width on `ack_o`. It also makes the type byte be read in the wrong window, so `entry_type` picks up the filler value that is on the bus outside the second pulse. A flag-update error is visible on `if_o`, `tf_o` and the saved-flag fields one cycle after an acceptance, a return or a write.

// File: rtl/int_entry_pkg.sv
package int_entry_pkg;

  typedef enum logic [1:0] {
    CLS_FAULT = 2'd0,
    CLS_NMI   = 2'd1,
    CLS_SWI   = 2'd2,
    CLS_EXT   = 2'd3
  } irq_class_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ACK  = 2'd1,
    SQ_OUT  = 2'd2
  } seq_state_e;

  localparam int unsigned NMI_TYPE_NUM = 2;

endpackage

// File: rtl/nmi_edge_det.sv
module nmi_edge_det #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clr,
  output logic pend
);

  logic [HOLD-1:0] hist;
  logic            qual;

  // The pin must be high now and in the last HOLD-1 samples, and low just before that.
  assign qual = pin && (&hist[HOLD-2:0]) && !hist[HOLD-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      pend <= 1'b0;
    end else begin
      hist <= {hist[HOLD-2:0], pin};
      if (qual)
        pend <= 1'b1;
      else if (clr)
        pend <= 1'b0;
    end
  end

  AST_NMI_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(pin) && $past(pin, 2)); // R6

endmodule

// File: rtl/type_latch.sv
module type_latch #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [TW-1:0] set_type,
  input  logic          clr,
  output logic          eff_v,
  output logic [TW-1:0] eff_t
);

  logic          pend;
  logic [TW-1:0] ptype;

  // Merged view: a strobe in the current cycle counts as pending now.
  assign eff_v = pend | set;
  assign eff_t = pend ? ptype : set_type;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      ptype <= '0;
    end else if (clr) begin
      pend  <= 1'b0;
    end else if (set && !pend) begin
      pend  <= 1'b1;
      ptype <= set_type;
    end
  end

  AST_CLR_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> eff_v); // R10

endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import int_entry_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic          flt_v,
  input  logic [TW-1:0] flt_t,
  input  logic          nmi_v,
  input  logic          swi_v,
  input  logic [TW-1:0] swi_t,
  input  logic          ext_v,
  output logic          any,
  output irq_class_e    cls,
  output logic [TW-1:0] typ
);

  always_comb begin
    any = flt_v | nmi_v | swi_v | ext_v;
    cls = CLS_EXT;
    typ = '0;
    if (flt_v) begin
      cls = CLS_FAULT;
      typ = flt_t;
    end else if (nmi_v) begin
      cls = CLS_NMI;
      typ = TW'(NMI_TYPE_NUM);
    end else if (swi_v) begin
      cls = CLS_SWI;
      typ = swi_t;
    end
  end

endmodule

// File: rtl/ack_seq.sv
module ack_seq #(
  parameter int unsigned TW      = 8,
  parameter int unsigned ACK_LEN = 2,
  parameter int unsigned ACK_GAP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] bus,
  output logic          ack,
  output logic          done,
  output logic [TW-1:0] dtype
);

  localparam int unsigned CMAX = (ACK_LEN > ACK_GAP) ? ACK_LEN : ACK_GAP;
  localparam int unsigned CW   = $clog2(CMAX) + 1;
  localparam logic [CW-1:0] LEN_M1 = CW'(ACK_LEN - 1);
  localparam logic [CW-1:0] GAP_M1 = CW'(ACK_GAP - 1);

  typedef enum logic [1:0] {PH_FIRST, PH_GAP, PH_SECOND} ack_phase_e;

  logic          busy;
  ack_phase_e    phase;
  logic [CW-1:0] cnt;

  assign ack   = busy && (phase != PH_GAP);
  assign done  = busy && (phase == PH_SECOND) && (cnt == LEN_M1);
  assign dtype = bus;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= PH_FIRST;
      cnt   <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      phase <= PH_FIRST;
      cnt   <= '0;
    end else if (busy) begin
      case (phase)
        PH_FIRST: begin
          if (cnt == LEN_M1) begin
            phase <= PH_GAP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_GAP: begin
          if (cnt == GAP_M1) begin
            phase <= PH_SECOND;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == LEN_M1) begin
            busy <= 1'b0;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R4
  AST_ACK_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ack); // R4

endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
  import int_entry_pkg::*;
#(
  parameter int unsigned TW       = 8,
  parameter int unsigned ACK_LEN  = 2,
  parameter int unsigned ACK_GAP  = 2,
  parameter int unsigned NMI_HOLD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_end,
  input  logic          intr_lvl,
  input  logic          nmi_pin,
  input  logic          swi_stb,
  input  logic [TW-1:0] swi_type,
  input  logic          flt_stb,
  input  logic [TW-1:0] flt_type,
  output logic          ack_o,
  input  logic [TW-1:0] ack_data,
  input  logic          flag_wr,
  input  logic          flag_if,
  input  logic          flag_tf,
  input  logic          iret_stb,
  input  logic          iret_if,
  input  logic          iret_tf,
  output logic          if_o,
  output logic          tf_o,
  output logic          entry_valid,
  input  logic          entry_ready,
  output logic [1:0]    entry_class,
  output logic [TW-1:0] entry_type,
  output logic [TW+1:0] entry_off_addr,
  output logic [TW+1:0] entry_seg_addr,
  output logic          entry_sv_if,
  output logic          entry_sv_tf
);

  localparam int unsigned VW = TW + 2;

  seq_state_e    state;
  logic          flt_v, swi_v, nmi_v, ext_v;
  logic [TW-1:0] flt_t, swi_t;
  logic          pick_any;
  irq_class_e    pick_cls;
  logic [TW-1:0] pick_typ;
  logic          take, accept;
  logic          ack_done;
  logic [TW-1:0] ack_type;
  irq_class_e    cls_r;
  logic [TW-1:0] typ_r;

  assign take   = (state == SQ_IDLE) && insn_end && pick_any;
  assign accept = entry_valid && entry_ready;
  assign ext_v  = intr_lvl && if_o;

  type_latch #(.TW(TW)) u_flt (
    .clk(clk), .rst_n(rst_n), .set(flt_stb), .set_type(flt_type),
    .clr(take && pick_cls == CLS_FAULT), .eff_v(flt_v), .eff_t(flt_t)
  );

  type_latch #(.TW(TW)) u_swi (
    .clk(clk), .rst_n(rst_n), .set(swi_stb), .set_type(swi_type),
    .clr(take && pick_cls == CLS_SWI), .eff_v(swi_v), .eff_t(swi_t)
  );

  nmi_edge_det #(.HOLD(NMI_HOLD)) u_nmi (
    .clk(clk), .rst_n(rst_n), .pin(nmi_pin),
    .clr(take && pick_cls == CLS_NMI), .pend(nmi_v)
  );

  prio_pick #(.TW(TW)) u_pick (
    .flt_v(flt_v), .flt_t(flt_t), .nmi_v(nmi_v), .swi_v(swi_v),
    .swi_t(swi_t), .ext_v(ext_v), .any(pick_any), .cls(pick_cls),
    .typ(pick_typ)
  );

  ack_seq #(.TW(TW), .ACK_LEN(ACK_LEN), .ACK_GAP(ACK_GAP)) u_ack (
    .clk(clk), .rst_n(rst_n), .start(take && pick_cls == CLS_EXT),
    .bus(ack_data), .ack(ack_o), .done(ack_done), .dtype(ack_type)
  );

  // Entry sequencing and output item register.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      entry_valid <= 1'b0;
      cls_r       <= CLS_FAULT;
      typ_r       <= '0;
      entry_sv_if <= 1'b0;
      entry_sv_tf <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (take) begin
            entry_sv_if <= if_o;
            entry_sv_tf <= tf_o;
            if (pick_cls == CLS_EXT) begin
              state <= SQ_ACK;
            end else begin
              entry_valid <= 1'b1;
              cls_r       <= pick_cls;
              typ_r       <= pick_typ;
              state       <= SQ_OUT;
            end
          end
        end
        SQ_ACK: begin
          if (ack_done) begin
            entry_valid <= 1'b1;
            cls_r       <= CLS_EXT;
            typ_r       <= ack_type;
            state       <= SQ_OUT;
          end
        end
        default: begin
          if (entry_ready) begin
            entry_valid <= 1'b0;
            state       <= SQ_IDLE;
          end
        end
      endcase
    end
  end

  // Flag register: entry acceptance beats return, return beats a plain write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if_o <= 1'b0;
      tf_o <= 1'b0;
    end else if (accept) begin
      if_o <= 1'b0;
      tf_o <= 1'b0;
    end else if (iret_stb) begin
      if_o <= iret_if;
      tf_o <= iret_tf;
    end else if (flag_wr) begin
      if_o <= flag_if;
      tf_o <= flag_tf;
    end
  end

  assign entry_class    = cls_r;
  assign entry_type     = typ_r;
  assign entry_off_addr = {typ_r, 2'b00};
  assign entry_seg_addr = {typ_r, 2'b10};

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid && !entry_ready |=> entry_valid && $stable(entry_type) && $stable(entry_class)); // R8
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid && entry_ready |=> !if_o && !tf_o); // R8
  AST_NO_ACK_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> !ack_o); // R4
  AST_NMI_TYPE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid && entry_class == CLS_NMI |-> entry_type == TW'(NMI_TYPE_NUM)); // R6
  AST_VEC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> entry_seg_addr == entry_off_addr + VW'(2)); // R7

endmodule

// File: tb/int_entry_seq_tb.sv
module int_entry_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       insn_end = 0, intr_lvl = 0, nmi_pin = 0;
  logic       swi_stb = 0, flt_stb = 0;
  logic [7:0] swi_type = 0, flt_type = 0, ack_data = 8'hEE;
  logic       flag_wr = 0, flag_if = 0, flag_tf = 0;
  logic       iret_stb = 0, iret_if = 0, iret_tf = 0;
  logic       entry_ready = 1;
  logic       ack_o, if_o, tf_o, entry_valid, entry_sv_if, entry_sv_tf;
  logic [1:0] entry_class;
  logic [7:0] entry_type;
  logic [9:0] entry_off_addr, entry_seg_addr;

  always #5 clk = ~clk;

  int_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .intr_lvl(intr_lvl),
    .nmi_pin(nmi_pin), .swi_stb(swi_stb), .swi_type(swi_type),
    .flt_stb(flt_stb), .flt_type(flt_type), .ack_o(ack_o), .ack_data(ack_data),
    .flag_wr(flag_wr), .flag_if(flag_if), .flag_tf(flag_tf),
    .iret_stb(iret_stb), .iret_if(iret_if), .iret_tf(iret_tf),
    .if_o(if_o), .tf_o(tf_o), .entry_valid(entry_valid),
    .entry_ready(entry_ready), .entry_class(entry_class),
    .entry_type(entry_type), .entry_off_addr(entry_off_addr),
    .entry_seg_addr(entry_seg_addr), .entry_sv_if(entry_sv_if),
    .entry_sv_tf(entry_sv_tf)
  );

  typedef struct {
    int    cls;
    int    typ;
    int    sif;
    int    stf;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0, n_fail = 0, accepted = 0;
  int   ack_pulses = 0, ack_hi = 0;
  logic ack_prev = 0;
  logic [7:0] ext_type = 8'h47;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic push(input int cls, input int typ, input int sif, input int stf,
                      input string req);
    exp_t e;
    e.cls = cls; e.typ = typ; e.sif = sif; e.stf = stf; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic boundary(input int wait_cycles);
    @(negedge clk); insn_end = 1;
    @(negedge clk); insn_end = 0;
    repeat (wait_cycles) @(negedge clk);
  endtask

  task automatic set_flags(input logic fi, input logic ft);
    @(negedge clk); flag_wr = 1; flag_if = fi; flag_tf = ft;
    @(negedge clk); flag_wr = 0;
  endtask

  task automatic nmi_high(input int cycles);
    @(negedge clk); nmi_pin = 1;
    repeat (cycles) @(negedge clk);
    nmi_pin = 0;
  endtask

  // Monitor: pops an expected item on every accepted entry.
  always @(negedge clk) begin
    #1;
    if (rst_n && entry_valid && entry_ready) begin
      accepted++;
      if (exp_q.size() == 0) begin
        chk(0, "R2", "unexpected entry class", int'(entry_class), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(int'(entry_class) == e.cls, e.req, "class", int'(entry_class), e.cls);
        chk(int'(entry_type) == e.typ, e.req, "type", int'(entry_type), e.typ);
        chk(int'(entry_off_addr) == e.typ * 4, "R7", "offset addr",
            int'(entry_off_addr), e.typ * 4);
        chk(int'(entry_seg_addr) == e.typ * 4 + 2, "R7", "segment addr",
            int'(entry_seg_addr), e.typ * 4 + 2);
        chk(int'(entry_sv_if) == e.sif, "R8", "saved if", int'(entry_sv_if), e.sif);
        chk(int'(entry_sv_tf) == e.stf, "R8", "saved tf", int'(entry_sv_tf), e.stf);
      end
    end
  end

  // External controller model: correct type byte only during the second pulse.
  always @(negedge clk) begin
    #1;
    if (ack_o && !ack_prev) ack_pulses++;
    if (ack_o) ack_hi++;
    ack_prev = ack_o;
    ack_data = (ack_o && ack_pulses == 2) ? ext_type : 8'hEE;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seen;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(entry_valid == 0, "R1", "entry_valid", entry_valid, 0);
    chk(ack_o == 0, "R1", "ack_o", ack_o, 0);
    chk(if_o == 0 && tf_o == 0, "R1", "flags", {if_o, tf_o}, 0);

    // R9 flag write
    set_flags(1, 1);
    chk(if_o == 1 && tf_o == 1, "R9", "flag write", {if_o, tf_o}, 3);

    // R4 maskable entry with two acknowledge pulses
    ack_pulses = 0; ack_hi = 0;
    intr_lvl = 1;
    push(3, 8'h47, 1, 1, "R4");
    boundary(12);
    intr_lvl = 0;
    chk(ack_pulses == 2, "R4", "ack pulses", ack_pulses, 2);
    chk(ack_hi == 4, "R4", "ack high cycles", ack_hi, 4);
    chk(if_o == 0 && tf_o == 0, "R8", "flags after accept", {if_o, tf_o}, 0);

    // R3 masked level ignored
    seen = accepted; ack_pulses = 0;
    intr_lvl = 1;
    boundary(10);
    chk(ack_pulses == 0, "R3", "ack while masked", ack_pulses, 0);
    chk(accepted == seen, "R3", "entries while masked", accepted - seen, 0);
    // R3 enabled but no boundary
    set_flags(1, 0);
    repeat (8) @(negedge clk);
    chk(ack_pulses == 0, "R3", "ack without boundary", ack_pulses, 0);
    intr_lvl = 0;
    set_flags(0, 0);

    // R5 software and fault not masked
    @(negedge clk); swi_stb = 1; swi_type = 8'h21; insn_end = 1;
    push(2, 8'h21, 0, 0, "R5");
    @(negedge clk); swi_stb = 0; insn_end = 0;
    repeat (4) @(negedge clk);
    @(negedge clk); flt_stb = 1; flt_type = 8'h00; insn_end = 1;
    push(0, 8'h00, 0, 0, "R5");
    @(negedge clk); flt_stb = 0; insn_end = 0;
    repeat (4) @(negedge clk);

    // R2 / R10 priority with all four pending
    set_flags(1, 1);
    intr_lvl = 1;
    nmi_high(2);
    repeat (2) @(negedge clk);
    @(negedge clk); swi_stb = 1; swi_type = 8'h30; flt_stb = 1; flt_type = 8'h04;
    insn_end = 1;
    push(0, 8'h04, 1, 1, "R2");
    @(negedge clk); swi_stb = 0; flt_stb = 0; insn_end = 0;
    repeat (4) @(negedge clk);
    push(1, 2, 0, 0, "R2");
    boundary(4);
    push(2, 8'h30, 0, 0, "R10");
    boundary(4);
    seen = accepted;
    boundary(10);
    chk(accepted == seen, "R10", "maskable blocked after clear", accepted - seen, 0);
    set_flags(1, 0);
    ext_type = 8'hC8; ack_pulses = 0;
    push(3, 8'hC8, 1, 0, "R10");
    boundary(12);
    intr_lvl = 0;

    // R6 single-cycle glitch ignored
    seen = accepted;
    nmi_high(1);
    repeat (3) @(negedge clk);
    boundary(6);
    chk(accepted == seen, "R6", "glitch entries", accepted - seen, 0);

    // R8 back-pressure, R10 NMI kept during busy entry
    set_flags(1, 1);
    entry_ready = 0; ext_type = 8'h5A; ack_pulses = 0;
    intr_lvl = 1;
    push(3, 8'h5A, 1, 1, "R8");
    boundary(10);
    intr_lvl = 0;
    chk(entry_valid == 1, "R8", "valid under stall", entry_valid, 1);
    held = entry_type;
    nmi_high(2);
    @(negedge clk); insn_end = 1;
    @(negedge clk); insn_end = 0;
    chk(entry_valid == 1 && entry_type == held, "R8", "stable under stall",
        entry_type, held);
    entry_ready = 1;
    repeat (3) @(negedge clk);
    push(1, 2, 0, 0, "R6");
    boundary(4);

    // R9 return restores flags
    @(negedge clk); iret_stb = 1; iret_if = 1; iret_tf = 0;
    @(negedge clk); iret_stb = 0;
    chk(if_o == 1 && tf_o == 0, "R9", "iret flags", {if_o, tf_o}, 2);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "entries outstanding", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule